// File: doc/BRIEF.md
# Masked-Write General-Purpose I/O Port

This block is a 32-pin general-purpose I/O port that sits behind a simple 32-bit register bus. The bus has an address, a write strobe, write data and read data. Each pin has three pieces of state: a direction bit, an output latch and a synchronized sample of its input level. The block does not contain the pad drivers. It presents an output-enable vector and an output-value vector, and the pad ring builds the tri-state buffers from them.

Software never has to read-modify-write shared state. Direction is changed through two separate registers. Writing ones to the first turns the selected pins into outputs. Writing ones to the second turns the selected pins into inputs. The output latches are split into a lower and an upper half. A write to either half carries a per-bit mask in its top 16 bits next to the new values in its bottom 16 bits, so one write can change any subset of 16 latches and leave the rest alone. Input pins go through a two-flop synchronizer before they can be read.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, every pin is an input (`pin_oe` is all zeros) and every output latch holds 0 (`pin_out` is all zeros, and the reads of 0x08 and 0x0C return 0).
- R2: A write to offset 0x00 sets direction bit i to 1 (output) for every bit i that is 1 in the write data. Direction bits whose write bit is 0 keep their value.
- R3: A write to offset 0x04 clears direction bit i to 0 (input) for every bit i that is 1 in the write data. Direction bits whose write bit is 0 keep their value.
- R4: A write to offset 0x08 updates the latch of pin i (0 ≤ i ≤ 15) to write bit i only where write bit 16+i is 1. All other latches keep their value.
- R5: A write to offset 0x0C updates the latch of pin 16+i (0 ≤ i ≤ 15) to write bit i only where write bit 16+i is 1. All other latches keep their value.
- R6: A read of offset 0x10 returns the input level of all 32 pins (bit i = pin i), after a two-flop synchronizer. A level applied before clock edge k is visible after edge k+1 and not before.
- R7: A read of offset 0x00 returns the direction vector (1 = output). A read of 0x08 returns latches 15:0, and a read of 0x0C returns latches 31:16, each in bits 15:0 with zeros in bits 31:16. Every other offset, 0x04 included, reads as 0.
- R8: `pin_out` always shows the latch contents, whatever the direction. A latch written while its pin is an input keeps that value, and direction writes never alter a latch.
- R9: A cycle with the write strobe low, or a write to any offset other than 0x00, 0x04, 0x08 or 0x0C, changes neither the direction bits nor the latches.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe; a write takes effect at the next rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw input levels from the pads |
| pin_oe | output | 32 | Output enable per pin (1 = pin drives) |
| pin_out | output | 32 | Output value per pin (latch contents) |

## Verification
The checker tests these rules on every cycle after reset:
- set and clear writes change exactly the selected direction bits and no others;
- masked half-word writes change exactly the masked latches;
- idle or unmapped cycles leave `pin_oe` and `pin_out` stable;
- direction writes never move a latch;
- the internal write strobes are mutually exclusive;
- the upper half of a latch readback is zero.

Some behaviours only the bench scenarios can show:
- the two-edge latency of the input synchronizer, together with the reset state;
- a latch written while its pin is an input appearing on the pin once the pin turns into an output;
- the agreement of every readback with an arithmetic model, across per-pin sweeps and a long pseudo-random mix of writes.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int PORT_W   = 32;
  localparam int HALF_W   = PORT_W / 2;
  localparam int BUS_AW   = 8;

  localparam logic [BUS_AW-1:0] OFF_DIR_SET = 8'h00;
  localparam logic [BUS_AW-1:0] OFF_DIR_CLR = 8'h04;
  localparam logic [BUS_AW-1:0] OFF_OUT_LO  = 8'h08;
  localparam logic [BUS_AW-1:0] OFF_OUT_HI  = 8'h0C;
  localparam logic [BUS_AW-1:0] OFF_IN_LVL  = 8'h10;

  // New latch half: take val where msk is 1, keep old elsewhere.
  function automatic logic [HALF_W-1:0] masked_merge(
      input logic [HALF_W-1:0] old_v,
      input logic [HALF_W-1:0] val,
      input logic [HALF_W-1:0] msk);
    return (old_v & ~msk) | (val & msk);
  endfunction

  function automatic logic [PORT_W-1:0] dir_apply(
      input logic [PORT_W-1:0] old_v,
      input logic [PORT_W-1:0] sel,
      input logic              do_set,
      input logic              do_clr);
    logic [PORT_W-1:0] r;
    r = old_v;
    if (do_set) r = r | sel;
    if (do_clr) r = r & ~sel;
    return r;
  endfunction
endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W = BUS_AW
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              wr_dir_set,
  output logic              wr_dir_clr,
  output logic [1:0]        wr_half
);
  always_comb begin
    wr_dir_set = we && (addr == ADDR_W'(OFF_DIR_SET));
    wr_dir_clr = we && (addr == ADDR_W'(OFF_DIR_CLR));
    wr_half[0] = we && (addr == ADDR_W'(OFF_OUT_LO));
    wr_half[1] = we && (addr == ADDR_W'(OFF_OUT_HI));
  end
endmodule

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg
  import gpio_mask_pkg::*;
#(
  parameter int WIDTH = PORT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_set,
  input  logic             do_clr,
  input  logic [WIDTH-1:0] sel,
  output logic [WIDTH-1:0] dir_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      dir_q <= '0;
    else if (do_set || do_clr)
      dir_q <= dir_apply(dir_q, sel, do_set, do_clr);
  end
endmodule

// File: rtl/gpio_out_half.sv
module gpio_out_half
  import gpio_mask_pkg::*;
#(
  parameter int HW = HALF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [2*HW-1:0] wdata,
  output logic [HW-1:0] lat_q
);
  logic [HW-1:0] msk;
  logic [HW-1:0] val;
  assign msk = wdata[2*HW-1:HW];
  assign val = wdata[HW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n)
      lat_q <= '0;
    else if (wr)
      lat_q <= masked_merge(lat_q, val, msk);
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n)
          stage_q[s] <= '0;
        else if (s == 0)
          stage_q[s] <= raw;
        else
          stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign synced = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W      = BUS_AW,
  parameter int NUM_PINS    = PORT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [NUM_PINS-1:0] bus_wdata,
  output logic [NUM_PINS-1:0] bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic [NUM_PINS-1:0] pin_out
);
  localparam int HW = NUM_PINS / 2;

  // Named internal events, observed by the bound checker.
  logic       wr_dir_set;
  logic       wr_dir_clr;
  logic [1:0] wr_half;

  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] in_sync;
  logic [HW-1:0]       lat_half [2];

  gpio_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr       (bus_addr),
    .we         (bus_we),
    .wr_dir_set (wr_dir_set),
    .wr_dir_clr (wr_dir_clr),
    .wr_half    (wr_half)
  );

  gpio_dir_reg #(.WIDTH(NUM_PINS)) dir_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .do_set (wr_dir_set),
    .do_clr (wr_dir_clr),
    .sel    (bus_wdata),
    .dir_q  (dir_q)
  );

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      gpio_out_half #(.HW(HW)) half_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (wr_half[h]),
        .wdata (bus_wdata),
        .lat_q (lat_half[h])
      );
      assign pin_out[h*HW +: HW] = lat_half[h];
    end
  endgenerate

  gpio_in_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw    (pin_in),
    .synced (in_sync)
  );

  assign pin_oe = dir_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFF_DIR_SET): bus_rdata = dir_q;
      ADDR_W'(OFF_OUT_LO):  bus_rdata[HW-1:0] = lat_half[0];
      ADDR_W'(OFF_OUT_HI):  bus_rdata[HW-1:0] = lat_half[1];
      ADDR_W'(OFF_IN_LVL):  bus_rdata = in_sync;
      default:              bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk
  import gpio_mask_pkg::*;
#(
  parameter int ADDR_W   = BUS_AW,
  parameter int NUM_PINS = PORT_W
) (
  input logic                clk,
  input logic                rst_n,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [NUM_PINS-1:0] bus_wdata,
  input logic [NUM_PINS-1:0] bus_rdata,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] pin_out,
  input logic                wr_dir_set,
  input logic                wr_dir_clr,
  input logic [1:0]          wr_half
);
  localparam int HW = NUM_PINS / 2;

  logic wr_any_port;
  assign wr_any_port = bus_we && (bus_addr == ADDR_W'(OFF_DIR_SET) || bus_addr == ADDR_W'(OFF_DIR_CLR)
                    || bus_addr == ADDR_W'(OFF_OUT_LO) || bus_addr == ADDR_W'(OFF_OUT_HI));

  AST_DIR_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_DIR_SET)) |=>
      ((pin_oe & $past(bus_wdata)) == $past(bus_wdata)) &&
      ((pin_oe & ~$past(bus_wdata)) == ($past(pin_oe) & ~$past(bus_wdata)))); // R2

  AST_DIR_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_DIR_CLR)) |=>
      ((pin_oe & $past(bus_wdata)) == '0) &&
      ((pin_oe & ~$past(bus_wdata)) == ($past(pin_oe) & ~$past(bus_wdata)))); // R3

  AST_LO_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_OUT_LO)) |=>
      (((pin_out[HW-1:0] ^ $past(pin_out[HW-1:0])) & ~$past(bus_wdata[NUM_PINS-1:HW])) == '0) &&
      (((pin_out[HW-1:0] ^ $past(bus_wdata[HW-1:0])) & $past(bus_wdata[NUM_PINS-1:HW])) == '0) &&
      $stable(pin_out[NUM_PINS-1:HW])); // R4

  AST_HI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFF_OUT_HI)) |=>
      (((pin_out[NUM_PINS-1:HW] ^ $past(pin_out[NUM_PINS-1:HW])) & ~$past(bus_wdata[NUM_PINS-1:HW])) == '0) &&
      (((pin_out[NUM_PINS-1:HW] ^ $past(bus_wdata[HW-1:0])) & $past(bus_wdata[NUM_PINS-1:HW])) == '0) &&
      $stable(pin_out[HW-1:0])); // R5

  AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFF_OUT_LO) || bus_addr == ADDR_W'(OFF_OUT_HI) || bus_addr == ADDR_W'(OFF_DIR_CLR)) |->
      (bus_rdata[NUM_PINS-1:HW] == '0)); // R7

  AST_DIR_KEEPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_dir_set || wr_dir_clr) |=> $stable(pin_out)); // R8

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any_port |=> ($stable(pin_oe) && $stable(pin_out))); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_dir_set, wr_dir_clr, wr_half}) && (wr_any_port == (wr_dir_set || wr_dir_clr || (|wr_half)))); // R9
endmodule

bind gpio_mask_port gpio_mask_port_chk #(.ADDR_W(ADDR_W), .NUM_PINS(NUM_PINS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pin_oe     (pin_oe),
  .pin_out    (pin_out),
  .wr_dir_set (wr_dir_set),
  .wr_dir_clr (wr_dir_clr),
  .wr_half    (wr_half)
);

// File: tb/gpio_mask_port_tb.sv
module gpio_mask_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = 32'h0;
  logic [31:0] pin_oe;
  logic [31:0] pin_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] m_dir = 32'h0;
  logic [31:0] m_lat = 32'h0;
  logic [31:0] rng   = 32'h1234_5678;

  always #4 clk = ~clk;  // 125 MHz

  gpio_mask_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Bench model of one bus write, bit by bit.
  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    for (int i = 0; i < 32; i++) begin
      if (a == 8'h00 && d[i]) m_dir[i] = 1'b1;
      if (a == 8'h04 && d[i]) m_dir[i] = 1'b0;
    end
    for (int i = 0; i < 16; i++) begin
      if (a == 8'h08 && d[16+i]) m_lat[i]    = d[i];
      if (a == 8'h0C && d[16+i]) m_lat[16+i] = d[i];
    end
  endtask

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return m_dir;
      8'h08: return {16'h0, m_lat[15:0]};
      8'h0C: return {16'h0, m_lat[31:16]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic we);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = we;
    @(negedge clk);
    bus_we = 1'b0;
    if (we) model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic check_state(input string tag);
    logic [31:0] r;
    check({tag, " oe"}, pin_oe, m_dir);
    check({tag, " out"}, pin_out, m_lat);
    bus_read(8'h00, r); check({tag, " rd dir"}, r, m_dir);
    bus_read(8'h08, r); check({tag, " rd lo"}, r, {16'h0, m_lat[15:0]});
    bus_read(8'h0C, r); check({tag, " rd hi"}, r, {16'h0, m_lat[31:16]});
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h1, 32'h0);
    finish_up();
  end

  initial begin
    logic [31:0] r;
    pin_in = 32'hA5A5_5A5A;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_state("R1");
    pin_in = 32'h0;
    repeat (3) @(negedge clk);

    // R2/R3: walk one pin at a time into and out of output mode
    for (int i = 0; i < 32; i++) begin
      bus_write(8'h00, 32'h1 << i, 1'b1);
      check("R2 walk set", pin_oe, m_dir);
    end
    check("R2 all out", pin_oe, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i += 2) begin
      bus_write(8'h04, 32'h1 << i, 1'b1);
      check("R3 walk clr", pin_oe, m_dir);
    end
    check("R3 odd left", pin_oe, 32'hAAAA_AAAA);

    // R4/R5: single-bit masked writes per pin
    for (int i = 0; i < 32; i++) begin
      logic [7:0] a;
      a = (i < 16) ? 8'h08 : 8'h0C;
      bus_write(a, (32'h1 << (16 + (i % 16))) | 32'hFFFF, 1'b1);
      check((i < 16) ? "R4 walk" : "R5 walk", pin_out, m_lat);
    end
    check("R4 R5 all ones", pin_out, 32'hFFFF_FFFF);
    bus_write(8'h08, 32'h0000_FFFF, 1'b1);
    check("R4 zero mask keeps", pin_out, 32'hFFFF_FFFF);
    bus_write(8'h0C, 32'hFF00_0000, 1'b1);
    check("R5 mask writes zeros", pin_out, 32'h00FF_FFFF);

    // R8: latch written while pin is input shows once pin is output
    bus_write(8'h04, 32'h0001_0000, 1'b1);
    bus_write(8'h0C, 32'h0001_0000, 1'b1);
    check("R8 latch while input", pin_out[16], 1'b0);
    check("R8 pin still input", pin_oe[16], 1'b0);
    bus_write(8'h0C, 32'h0001_0001, 1'b1);
    bus_write(8'h00, 32'h0001_0000, 1'b1);
    check("R8 dir write keeps latch", pin_out, m_lat);
    check("R8 driven", {pin_oe[16], pin_out[16]}, 32'h3);

    // R9: strobe low and unmapped offsets change nothing
    bus_write(8'h00, 32'hFFFF_FFFF, 1'b0);
    check_state("R9 we low");
    bus_write(8'h10, 32'hFFFF_FFFF, 1'b1);
    check_state("R9 unmapped 10");
    bus_write(8'h14, 32'hFFFF_0000, 1'b1);
    check_state("R9 unmapped 14");
    bus_write(8'h09, 32'hFFFF_FFFF, 1'b1);
    check_state("R9 unaligned");

    // R7: readback of non-register offsets
    bus_read(8'h04, r); check("R7 rd 04", r, 32'h0);
    bus_read(8'h20, r); check("R7 rd 20", r, 32'h0);

    // R6: two-edge synchronizer latency
    for (int k = 0; k < 8; k++) begin
      logic [31:0] old_v;
      logic [31:0] new_v;
      rng = next_rnd(rng);
      @(negedge clk);
      bus_read(8'h10, old_v);
      new_v = ~old_v ^ (rng & 32'h0F0F_0F0F);
      pin_in = new_v;
      #1; check("R6 before edge", bus_rdata, old_v);
      @(negedge clk); #1; check("R6 one edge", bus_rdata, old_v);
      @(negedge clk); #1; check("R6 two edges", bus_rdata, new_v);
    end

    // Mixed pseudo-random sweep over all offsets (R2 R3 R4 R5 R7 R9)
    for (int k = 0; k < 400; k++) begin
      logic [7:0] a;
      rng = next_rnd(rng);
      case (rng[2:0])
        3'd0, 3'd1: a = 8'h00;
        3'd2:       a = 8'h04;
        3'd3, 3'd4: a = 8'h08;
        3'd5, 3'd6: a = 8'h0C;
        default:    a = 8'h14;
      endcase
      bus_write(a, next_rnd(rng ^ 32'h9E37_79B9), rng[3] | rng[4]);
      check("R2-mix oe", pin_oe, m_dir);
      check("R4-mix out", pin_out, m_lat);
      bus_read(a, r);
      check("R7 mix readback", r, model_read(a));
    end

    // R1: reset again returns everything to inputs and zero latches
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_dir = 32'h0;
    m_lat = 32'h0;
    check_state("R1 re-reset");

    finish_up();
  end
endmodule